// File: doc/BRIEF.md
# Power-Gated Rail Discharge Timer

This block sits in the controller that power-gates a core. On a test command it puts the core to sleep and starts counting clock cycles in the same cycle. It stops when the virtual supply rail, which drains only through the leakage of the gated core, is sensed at logic 0. Ageing raises transistor thresholds, and leakage falls steeply as thresholds rise, so the drain time grows quickly with use. The block compares the captured cycle count with a programmable threshold and flags the part as recycled when the count is larger.

The threshold is meant to sit a little above the slowest drain time seen on fresh parts. Fresh parts drain in roughly 207 to 225 ns. Parts with one month of use need at least about 456 ns. A threshold near 1.1 times the fresh nominal therefore separates the two groups.

The rail sense is asynchronous. It passes through a synchronizer, and the synchronizer latency is removed from the reported count. A programmable limit bounds the wait when the rail never drains. Sleep stays asserted after the measurement until a wake request arrives. Outside a test, a plain sleep request gates the core without measuring anything.

Top module: `rail_drain_timer`

## Requirements
- R1: When `start_test_i` is sampled high in the idle state while the synchronized rail reads 1, `sleep_o` and `measure_o` both go high on that same clock edge.
- R2: Call E0 the edge on which `sleep_o` rises. If `rail_sense_i` falls between edge Ek and edge Ek+1, and k <= limit, then `count_o` becomes k, `timeout_o` becomes 0, and `done_o` is high for exactly one cycle after edge Ek+3.
- R3: If the rail has not fallen by the end of the cycle after edge E(limit), the measurement ends at edge E(limit+3). At that edge `count_o` becomes the limit value and `timeout_o` becomes 1.
- R4: `recycled_o` is set together with `done_o` exactly when `count_o > threshold_i`, with the comparison unsigned and strict. It holds its value until the next start command is seen in idle.
- R5: After a measurement, `sleep_o` stays high until `wake_i` is sampled high. `wake_i` has no effect while a measurement is running. `sleep_o` falls on the edge that samples `wake_i`, and the block returns to idle once the synchronized rail reads 1 again.
- R6: The cycle counter advances only while `measure_o` and `sleep_o` are both high. `measure_o` is never high without `sleep_o`, and `count_o` changes only on an edge that raises `done_o`.
- R7: A start command sampled in idle while the synchronized rail reads 0 is ignored: `sleep_o` and `measure_o` stay low. In that case `error_o` goes to 1, `recycled_o` and `timeout_o` clear, and `count_o` keeps its value. The next accepted start clears `error_o`.
- R8: In idle with no test running, `sleep_o` follows `sleep_req_i` with a delay of one clock, and `measure_o` stays low.
- R9: While `rst_n` is low and on the first cycle after it is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every count is in its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Plain sleep request, honoured only in idle |
| start_test_i | input | 1 | Starts a drain measurement |
| wake_i | input | 1 | Ends sleep after a measurement |
| rail_sense_i | input | 1 | Asynchronous logic-level sense of the virtual rail |
| threshold_i | input | CW | Recycled verdict threshold in cycles |
| limit_i | input | CW | Largest count before a timeout |
| sleep_o | output | 1 | Gates the core when high |
| measure_o | output | 1 | High while the cycle counter runs |
| count_o | output | CW | Captured drain time in cycles |
| done_o | output | 1 | One-cycle pulse when a result is captured |
| recycled_o | output | 1 | Part judged aged |
| timeout_o | output | 1 | Rail did not drain within the limit |
| error_o | output | 1 | Start rejected because the rail was already low |

## Verification
The hardest case to produce from the ports is the one-cycle boundary between a drain detected on the last allowed cycle and a timeout. The two differ only in which edge the asynchronous sense falls before. The bench steps the fall edge one cycle at a time, from the sleep edge up to two cycles past the limit. It does this under two limit and threshold settings, so the strict threshold comparison, the limit-equals-count case and the timeout path are all met. It also holds the rail low in idle to force a rejected start straight after a recycled verdict, and it holds wake high during a measurement to show that wake is ignored there.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE          = 2'd0,
    ST_SLEEP_MEASURE = 2'd1,
    ST_DONE          = 2'd2,
    ST_WAKE          = 2'd3
  } rdt_state_e;

endpackage

// File: rtl/rdt_sync.sv
module rdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        chain_q[i] <= chain_q[i-1];
      end
      chain_q[0] <= d_i;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
  parameter int unsigned CW  = 16,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          at_limit_o,
  output logic [CW-1:0] drain_o
);

  localparam int unsigned RW = CW + 2;
  localparam logic [RW-1:0] LAT_W = RW'(LAT);
  localparam logic [RW-1:0] CW_MAX = {2'b00, {CW{1'b1}}};

  logic [RW-1:0] raw_q;

  // Advance by one, holding at the top of the range.
  function automatic logic [RW-1:0] step(input logic [RW-1:0] raw);
    if (raw == {RW{1'b1}}) return raw;
    return raw + 1'b1;
  endfunction

  // Drain time = raw cycles minus synchronizer latency, clamped to [0, CW max].
  function automatic logic [CW-1:0] drain_of(input logic [RW-1:0] raw);
    logic [RW-1:0] diff;
    if (raw <= LAT_W) return '0;
    diff = raw - LAT_W;
    if (diff > CW_MAX) return {CW{1'b1}};
    return diff[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (clr_i) begin
      raw_q <= '0;
    end else if (inc_i) begin
      raw_q <= step(raw_q);
    end
  end

  assign at_limit_o = raw_q >= ({2'b00, limit_i} + LAT_W);
  assign drain_o    = drain_of(raw_q);

endmodule

// File: rtl/rdt_fsm.sv
module rdt_fsm
  import rdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wake_i,
  input  logic sleep_req_i,
  input  logic rail_hi_i,
  input  logic at_limit_i,
  output logic sleep_o,
  output logic measure_o,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic finish_o,
  output logic finish_timeout_o,
  output logic start_seen_o,
  output logic start_bad_o
);

  rdt_state_e state_q, state_d;
  logic sleep_d, measure_d;

  assign start_seen_o     = (state_q == ST_IDLE) && start_i;
  assign start_bad_o      = start_seen_o && !rail_hi_i;
  assign cnt_clr_o        = start_seen_o && rail_hi_i;
  assign finish_timeout_o = (state_q == ST_SLEEP_MEASURE) && rail_hi_i && at_limit_i;
  assign finish_o         = (state_q == ST_SLEEP_MEASURE) && (!rail_hi_i || at_limit_i);
  assign cnt_inc_o        = (state_q == ST_SLEEP_MEASURE) && !finish_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:          if (cnt_clr_o) state_d = ST_SLEEP_MEASURE;
      ST_SLEEP_MEASURE: if (finish_o)  state_d = ST_DONE;
      ST_DONE:          if (wake_i)    state_d = ST_WAKE;
      ST_WAKE:          if (rail_hi_i) state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    measure_d = (state_d == ST_SLEEP_MEASURE);
    sleep_d   = (state_d == ST_SLEEP_MEASURE) || (state_d == ST_DONE) ||
                ((state_q == ST_IDLE) && (state_d == ST_IDLE) && sleep_req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sleep_o   <= 1'b0;
      measure_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      sleep_o   <= sleep_d;
      measure_o <= measure_d;
    end
  end

endmodule

// File: rtl/rdt_verdict.sv
module rdt_verdict #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish_i,
  input  logic          finish_timeout_i,
  input  logic          start_seen_i,
  input  logic          start_bad_i,
  input  logic [CW-1:0] drain_i,
  input  logic [CW-1:0] threshold_i,
  output logic [CW-1:0] count_o,
  output logic          done_o,
  output logic          recycled_o,
  output logic          timeout_o,
  output logic          error_o
);

  // Aged when the drain time is strictly longer than the threshold.
  function automatic logic is_aged(input logic [CW-1:0] cycles,
                                   input logic [CW-1:0] thr);
    return cycles > thr;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o    <= '0;
      done_o     <= 1'b0;
      recycled_o <= 1'b0;
      timeout_o  <= 1'b0;
      error_o    <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        count_o    <= drain_i;
        recycled_o <= is_aged(drain_i, threshold_i);
        timeout_o  <= finish_timeout_i;
      end else if (start_seen_i) begin
        recycled_o <= 1'b0;
        timeout_o  <= 1'b0;
        error_o    <= start_bad_i;
      end
    end
  end

endmodule

// File: rtl/rail_drain_timer.sv
module rail_drain_timer #(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req_i,
  input  logic          start_test_i,
  input  logic          wake_i,
  input  logic          rail_sense_i,
  input  logic [CW-1:0] threshold_i,
  input  logic [CW-1:0] limit_i,
  output logic          sleep_o,
  output logic          measure_o,
  output logic [CW-1:0] count_o,
  output logic          done_o,
  output logic          recycled_o,
  output logic          timeout_o,
  output logic          error_o
);

  logic          rail_hi;
  logic          at_limit;
  logic [CW-1:0] drain;
  logic          cnt_clr, cnt_inc;
  logic          finish, finish_timeout;
  logic          start_seen, start_bad;

  rdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rail_sense_i),
    .q_o   (rail_hi)
  );

  rdt_counter #(.CW(CW), .LAT(SYNC_STAGES)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cnt_clr),
    .inc_i      (cnt_inc),
    .limit_i    (limit_i),
    .at_limit_o (at_limit),
    .drain_o    (drain)
  );

  rdt_fsm u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_test_i),
    .wake_i           (wake_i),
    .sleep_req_i      (sleep_req_i),
    .rail_hi_i        (rail_hi),
    .at_limit_i       (at_limit),
    .sleep_o          (sleep_o),
    .measure_o        (measure_o),
    .cnt_clr_o        (cnt_clr),
    .cnt_inc_o        (cnt_inc),
    .finish_o         (finish),
    .finish_timeout_o (finish_timeout),
    .start_seen_o     (start_seen),
    .start_bad_o      (start_bad)
  );

  rdt_verdict #(.CW(CW)) u_verdict (
    .clk              (clk),
    .rst_n            (rst_n),
    .finish_i         (finish),
    .finish_timeout_i (finish_timeout),
    .start_seen_i     (start_seen),
    .start_bad_i      (start_bad),
    .drain_i          (drain),
    .threshold_i      (threshold_i),
    .count_o          (count_o),
    .done_o           (done_o),
    .recycled_o       (recycled_o),
    .timeout_o        (timeout_o),
    .error_o          (error_o)
  );

endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_req_i,
  input logic          wake_i,
  input logic [CW-1:0] threshold_i,
  input logic [CW-1:0] limit_i,
  input logic          sleep_o,
  input logic          measure_o,
  input logic [CW-1:0] count_o,
  input logic          done_o,
  input logic          recycled_o,
  input logic          timeout_o,
  input logic          error_o,
  input logic          cnt_inc
);

  assert_rise_together_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(measure_o) |-> ($rose(sleep_o) || $past(sleep_req_i)));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_timeout_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> (count_o == limit_i));

  assert_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (recycled_o == (count_o > threshold_i)));

  assert_hold_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wake_i) |=> sleep_o);

  assert_measure_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    measure_o |-> sleep_o);

  assert_inc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> (measure_o && sleep_o));

  assert_count_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> done_o);

  assert_reject_no_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> !measure_o);

endmodule

bind rail_drain_timer rdt_checker #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req_i (sleep_req_i),
  .wake_i      (wake_i),
  .threshold_i (threshold_i),
  .limit_i     (limit_i),
  .sleep_o     (sleep_o),
  .measure_o   (measure_o),
  .count_o     (count_o),
  .done_o      (done_o),
  .recycled_o  (recycled_o),
  .timeout_o   (timeout_o),
  .error_o     (error_o),
  .cnt_inc     (cnt_inc)
);

// File: tb/tb_rail_drain_timer.sv
module tb_rail_drain_timer;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0;
  logic          start = 1'b0;
  logic          wake = 1'b0;
  logic          rail = 1'b1;
  logic [CW-1:0] thr = '0;
  logic [CW-1:0] lim = '0;
  logic          sleep_o, measure_o, done_o, recycled_o, timeout_o, error_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rail_drain_timer #(.CW(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .start_test_i(start),
    .wake_i(wake), .rail_sense_i(rail), .threshold_i(thr), .limit_i(lim),
    .sleep_o(sleep_o), .measure_o(measure_o), .count_o(count_o), .done_o(done_o),
    .recycled_o(recycled_o), .timeout_o(timeout_o), .error_o(error_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic all_low(input string req);
    int v;
    v = {sleep_o, measure_o, done_o, recycled_o, timeout_o, error_o};
    check(v == 0 && count_o == 0, req, v + int'(count_o), 0);
  endtask

  // One measurement: rail falls after edge k (never when k > limit).
  task automatic run_one(input int k, input int l, input int t, input bit hold_wake);
    int e;
    int exp_cnt, exp_edge;
    bit exp_to, exp_rec;
    exp_to   = (k > l);
    exp_cnt  = exp_to ? l : k;
    exp_edge = exp_to ? l + 3 : k + 3;
    exp_rec  = (exp_cnt > t);
    @(negedge clk); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    check(sleep_o && measure_o, "R1 sleep+measure rise", {sleep_o, measure_o}, 3);
    if (hold_wake) wake = 1'b1;
    e = 0;
    if (k == 0) rail = 1'b0;
    forever begin
      @(posedge clk); e++;
      @(negedge clk);
      if (done_o || e > 400) break;
      if (e == k && !exp_to) begin
        if (hold_wake) begin
          check(sleep_o && measure_o, "R5 wake ignored while measuring",
                {sleep_o, measure_o}, 3);
          wake = 1'b0;
        end
        rail = 1'b0;
      end
    end
    check(e == exp_edge, exp_to ? "R3 done edge" : "R2 done edge", e, exp_edge);
    check(int'(count_o) == exp_cnt, exp_to ? "R3 count" : "R2 count", count_o, exp_cnt);
    check(timeout_o == exp_to, exp_to ? "R3 timeout" : "R2 timeout", timeout_o, exp_to);
    check(recycled_o == exp_rec, "R4 verdict", recycled_o, exp_rec);
    @(negedge clk);
    check(!done_o, "R2 done one cycle", done_o, 0);
    check(sleep_o && !measure_o, "R5 sleep held", {sleep_o, measure_o}, 2);
    wake = 1'b1; rail = 1'b1;
    @(negedge clk); wake = 1'b0;
    check(!sleep_o, "R5 sleep drops on wake", sleep_o, 0);
    check(recycled_o == exp_rec, "R4 verdict held", recycled_o, exp_rec);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    all_low("R9 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    all_low("R9 after reset");
    repeat (4) @(negedge clk);

    // R8: plain sleep request in idle
    sleep_req = 1'b1;
    @(negedge clk);
    check(sleep_o && !measure_o, "R8 sleep follows request", {sleep_o, measure_o}, 2);
    sleep_req = 1'b0;
    @(negedge clk);
    check(!sleep_o && count_o == 0, "R8 sleep released", sleep_o, 0);

    for (int c = 0; c < 2; c++) begin
      lim = (c == 0) ? 8'd15 : 8'd4;
      thr = (c == 0) ? 8'd10 : 8'd2;
      for (int k = 0; k <= int'(lim) + 2; k++) begin
        run_one(k, int'(lim), int'(thr), (c == 0 && k == 6));
      end
    end

    // R7: start while rail already low, right after a recycled verdict
    last = int'(count_o);
    rail = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!sleep_o && !measure_o, "R7 start ignored", {sleep_o, measure_o}, 0);
    check(error_o, "R7 error set", error_o, 1);
    check(!recycled_o && !timeout_o, "R7 flags cleared", {recycled_o, timeout_o}, 0);
    check(int'(count_o) == last, "R7 count held", count_o, last);
    repeat (2) @(negedge clk);
    check(!sleep_o && !measure_o, "R7 still idle", {sleep_o, measure_o}, 0);
    rail = 1'b1;
    repeat (3) @(negedge clk);
    run_one(3, int'(lim), int'(thr), 1'b0);
    check(!error_o, "R7 error cleared by accepted start", error_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule